// File: doc/BRIEF.md
# Pipelined Radix-2 Decimation-in-Frequency Butterfly

This block is the arithmetic core of one stage of a streaming FFT. On each enabled clock it takes two complex samples `a` and `b` and a complex twiddle `c`. It returns `a + b` on the left output and `(a - b) * c` on the right output. Each complex word is packed with the real part in the upper half and the imaginary part in the lower half, and both parts are two's complement. The twiddle has `CW` bits per part and is scaled so that unit magnitude equals `2^(CW-2)`.

A sync flag travels alongside the data and marks the first pair of each transform. The block is pipelined, and every register advances only on clocks where `ce_i` is high. The `CKPCE` parameter sets how many real multipliers form the complex product:
- `CKPCE = 1`: three multipliers, and a new pair can be accepted every clock.
- `CKPCE = 2`: two multipliers, with at least one idle clock required between enables.
- `CKPCE = 3`: one multiplier, with at least two idle clocks required between enables.

The idle clocks are used to take partial products in turn. Outputs and latency are the same in all three settings.

Top module: `dif_butterfly`

## Requirements
- R1: `left_o` carries `a+b`, computed per part with one bit of growth. The real part is in bits `[2*OW-1:OW]` and the imaginary part in `[OW-1:0]`. When `OW` is below `IW+1` the sum is rounded half-to-even; otherwise it is sign-extended.
- R2: `right_o` carries `(a-b)*c`. Real part = `dr*cr - di*ci`; imaginary part = `dr*ci + di*cr`. The product is divided by `2^(CW-2+SHIFT)`, rounded, and then kept as its low `OW` bits, with the same packing as R1.
- R3: Rounding of the product is half-to-even: exact halves go to the nearest even result. For example, 0.5 gives 0, 1.5 gives 2, -0.5 gives 0 and 2.5 gives 2.
- R4: The result pair for inputs sampled at enabled edge n appears on both outputs together, right after enabled edge n+2.
- R5: On clocks with `ce_i` low, no output changes, and the values on `a_i`, `b_i`, `c_i` and `sync_i` are ignored.
- R6: `sync_o` is high exactly while the result pair of a vector accepted with `sync_i` high is on the outputs. It is low otherwise.
- R7: `rst_ni` low clears the sync pipeline asynchronously. `sync_o` is low during reset and stays low afterwards, even for a sync that was in flight when reset arrived.
- R8: With `CKPCE = 1`, the block accepts a new pair on every clock.
- R9: With `CKPCE = 2` (at least one idle clock between enables) or `CKPCE = 3` (at least two), results and latency match R1 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sync path |
| ce_i | input | 1 | Clock enable; pipeline advances only when high |
| sync_i | input | 1 | Marks the first pair of a transform |
| a_i | input | 2*IW | Even sample, real upper / imaginary lower |
| b_i | input | 2*IW | Odd sample, same packing |
| c_i | input | 2*CW | Twiddle coefficient, same packing |
| left_o | output | 2*OW | Sum output |
| right_o | output | 2*OW | Twiddled difference output |
| sync_o | output | 1 | Sync aligned with the result pair |

## Verification
The hardest situation to reach is the shared-multiplier variants under irregular enable gaps. In those variants partial products are captured on idle clocks, while the input bus keeps changing and carries spurious sync pulses. The bench therefore drives gaps of two, three and four idle clocks with random data and `sync_i` held high on every idle clock. It then checks that only the enabled vectors shape the results. A sweep over every real-part pair of the difference, crossed with extreme coefficients such as the most negative value, reaches the rounding ties and the output wrap. A reset is also applied while a sync is in flight.

// File: rtl/dif_bfly_pkg.sv
`timescale 1ns/1ps
package dif_bfly_pkg;

  // real multipliers instantiated for a given clocks-per-enable setting
  function automatic int mults_for(input int ckpce);
    case (ckpce)
      2:       return 2;
      3:       return 1;
      default: return 3;
    endcase
  endfunction

  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_C = 2'd2
  } share_ph_e;

endpackage

// File: rtl/bfly_cround.sv
`timescale 1ns/1ps
module bfly_cround #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8,
  parameter int DROP  = 0
) (
  input  logic signed [IN_W-1:0]  val_i,
  output logic signed [OUT_W-1:0] val_o
);
  localparam int RW = IN_W - DROP + 1;

  logic signed [RW-1:0] rnd;

  generate
    if (DROP > 0) begin : g_round
      logic signed [IN_W:0] ext, bias, summed;
      always_comb begin
        ext    = {val_i[IN_W-1], val_i};
        // half minus one when the kept lsb is even, so ties stay even
        bias   = ({{IN_W{1'b0}}, 1'b1} << (DROP - 1)) - {{IN_W{1'b0}}, !val_i[DROP]};
        summed = ext + bias;
        rnd    = summed[IN_W:DROP];
      end
    end else begin : g_pass
      always_comb rnd = {val_i[IN_W-1], val_i};
    end

    if (OUT_W <= RW) begin : g_narrow
      assign val_o = rnd[OUT_W-1:0];
    end else begin : g_wide
      assign val_o = {{(OUT_W-RW){rnd[RW-1]}}, rnd};
    end
  endgenerate

endmodule

// File: rtl/bfly_cmult.sv
`timescale 1ns/1ps
module bfly_cmult #(
  parameter int DW    = 17,
  parameter int CW    = 20,
  parameter int PW    = DW + CW + 2,
  parameter int CKPCE = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_i,
  input  logic signed [DW-1:0] dre_i,
  input  logic signed [DW-1:0] dim_i,
  input  logic signed [CW-1:0] cre_i,
  input  logic signed [CW-1:0] cim_i,
  output logic signed [PW-1:0] pre_o,
  output logic signed [PW-1:0] pim_o
);
  import dif_bfly_pkg::*;

  localparam int NMULT = mults_for(CKPCE);

  logic signed [PW-1:0] dr, di, cr, ci;
  logic signed [PW-1:0] pre_q, pim_q;

  assign dr = {{(PW-DW){dre_i[DW-1]}}, dre_i};
  assign di = {{(PW-DW){dim_i[DW-1]}}, dim_i};
  assign cr = {{(PW-CW){cre_i[CW-1]}}, cre_i};
  assign ci = {{(PW-CW){cim_i[CW-1]}}, cim_i};

  generate
    if (NMULT == 3) begin : g_three
      logic signed [PW-1:0] t1, t2, t3;
      always_comb begin
        t1 = cr * (dr + di);
        t2 = di * (cr + ci);
        t3 = dr * (ci - cr);
      end
      always_ff @(posedge clk_i) begin
        if (ce_i) begin
          pre_q <= t1 - t2;
          pim_q <= t1 + t3;
        end
      end
    end else if (NMULT == 2) begin : g_two
      logic signed [PW-1:0] opb0, opb1, m0, m1, rr_q, ii_q;
      always_comb begin
        opb0 = ce_i ? ci : cr;
        opb1 = ce_i ? cr : ci;
        m0   = dr * opb0;
        m1   = di * opb1;
      end
      // direct products taken on the idle clock
      always_ff @(posedge clk_i) begin
        if (!ce_i) begin
          rr_q <= m0;
          ii_q <= m1;
        end
      end
      always_ff @(posedge clk_i) begin
        if (ce_i) begin
          pre_q <= rr_q - ii_q;
          pim_q <= m0 + m1;
        end
      end
    end else begin : g_one
      share_ph_e            ph_q;
      logic signed [PW-1:0] xa, xb, m, t1_q, t2_q;
      always_comb begin
        if (ce_i) begin
          xa = dr;
          xb = ci - cr;
        end else if (ph_q == PH_A) begin
          xa = cr;
          xb = dr + di;
        end else begin
          xa = di;
          xb = cr + ci;
        end
        m = xa * xb;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             ph_q <= PH_A;
        else if (ce_i)           ph_q <= PH_A;
        else if (ph_q == PH_A)   ph_q <= PH_B;
        else                     ph_q <= PH_C;
      end
      always_ff @(posedge clk_i) begin
        if (!ce_i) begin
          if (ph_q == PH_A)      t1_q <= m;
          else if (ph_q == PH_B) t2_q <= m;
        end
      end
      always_ff @(posedge clk_i) begin
        if (ce_i) begin
          pre_q <= t1_q - t2_q;
          pim_q <= t1_q + m;
        end
      end
    end
  endgenerate

  assign pre_o = pre_q;
  assign pim_o = pim_q;

  // enable spacing monitor for the shared variants
  logic [1:0] idle_cnt_q;
  logic       seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt_q <= 2'd0;
      seen_q     <= 1'b0;
    end else if (ce_i) begin
      idle_cnt_q <= 2'd0;
      seen_q     <= 1'b1;
    end else if (idle_cnt_q != 2'd3) begin
      idle_cnt_q <= idle_cnt_q + 2'd1;
    end
  end

  // R9
  gap_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && seen_q) |-> (idle_cnt_q >= 2'(CKPCE - 1)));

  // R5
  prod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(pre_o) && $stable(pim_o)));

endmodule

// File: rtl/dif_butterfly.sv
`timescale 1ns/1ps
module dif_butterfly #(
  parameter int IW    = 16,
  parameter int CW    = 20,
  parameter int OW    = 17,
  parameter int SHIFT = 0,
  parameter int CKPCE = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_i,
  input  logic            sync_i,
  input  logic [2*IW-1:0] a_i,
  input  logic [2*IW-1:0] b_i,
  input  logic [2*CW-1:0] c_i,
  output logic [2*OW-1:0] left_o,
  output logic [2*OW-1:0] right_o,
  output logic            sync_o
);
  localparam int DW    = IW + 1;
  localparam int PW    = DW + CW + 2;
  localparam int SDROP = (DW > OW) ? (DW - OW) : 0;
  localparam int PDROP = CW - 2 + SHIFT;

  logic signed [IW-1:0] ar, ai, br, bi;
  assign ar = a_i[2*IW-1:IW];
  assign ai = a_i[IW-1:0];
  assign br = b_i[2*IW-1:IW];
  assign bi = b_i[IW-1:0];

  // stage A: add/subtract and coefficient capture
  logic signed [DW-1:0] sre_a_q, sim_a_q, dre_a_q, dim_a_q;
  logic signed [CW-1:0] cre_a_q, cim_a_q;
  always_ff @(posedge clk_i) begin
    if (ce_i) begin
      sre_a_q <= DW'(ar) + DW'(br);
      sim_a_q <= DW'(ai) + DW'(bi);
      dre_a_q <= DW'(ar) - DW'(br);
      dim_a_q <= DW'(ai) - DW'(bi);
      cre_a_q <= c_i[2*CW-1:CW];
      cim_a_q <= c_i[CW-1:0];
    end
  end

  // stage B: sum held to match the multiply register
  logic signed [DW-1:0] sre_b_q, sim_b_q;
  always_ff @(posedge clk_i) begin
    if (ce_i) begin
      sre_b_q <= sre_a_q;
      sim_b_q <= sim_a_q;
    end
  end

  logic signed [PW-1:0] pre_b, pim_b;
  bfly_cmult #(.DW(DW), .CW(CW), .PW(PW), .CKPCE(CKPCE)) u_cmult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .dre_i  (dre_a_q),
    .dim_i  (dim_a_q),
    .cre_i  (cre_a_q),
    .cim_i  (cim_a_q),
    .pre_o  (pre_b),
    .pim_o  (pim_b)
  );

  // lane 1 = real, lane 0 = imaginary
  logic signed [DW-1:0] s_lane [2];
  logic signed [PW-1:0] p_lane [2];
  logic signed [OW-1:0] s_rnd  [2];
  logic signed [OW-1:0] p_rnd  [2];

  assign s_lane[1] = sre_b_q;
  assign s_lane[0] = sim_b_q;
  assign p_lane[1] = pre_b;
  assign p_lane[0] = pim_b;

  generate
    for (genvar k = 0; k < 2; k++) begin : g_lane
      bfly_cround #(.IN_W(DW), .OUT_W(OW), .DROP(SDROP)) u_sum_rnd (
        .val_i (s_lane[k]),
        .val_o (s_rnd[k])
      );
      bfly_cround #(.IN_W(PW), .OUT_W(OW), .DROP(PDROP)) u_prod_rnd (
        .val_i (p_lane[k]),
        .val_o (p_rnd[k])
      );
    end
  endgenerate

  logic [2*OW-1:0] left_q, right_q;
  always_ff @(posedge clk_i) begin
    if (ce_i) begin
      left_q  <= {s_rnd[1], s_rnd[0]};
      right_q <= {p_rnd[1], p_rnd[0]};
    end
  end

  logic sync_a_q, sync_b_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_a_q <= 1'b0;
      sync_b_q <= 1'b0;
      sync_q   <= 1'b0;
    end else if (ce_i) begin
      sync_a_q <= sync_i;
      sync_b_q <= sync_a_q;
      sync_q   <= sync_b_q;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign sync_o  = sync_q;

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(left_o) && $stable(right_o) && $stable(sync_o)));

  // R6
  sync_on_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(ce_i));

endmodule

// File: tb/tb_dif_butterfly.sv
`timescale 1ns/1ps
module tb_dif_butterfly;
  localparam int IW = 5;
  localparam int CW = 6;
  localparam int OW = 6;
  localparam int SH = 1;
  localparam int PD = CW - 2 + SH;

  typedef struct {
    logic [2*OW-1:0] l;
    logic [2*OW-1:0] r;
    bit              sy;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      ce_v = 3'b000;
  logic            sync = 1'b0;
  logic [2*IW-1:0] a = '0, b = '0;
  logic [2*CW-1:0] c = '0;

  logic [2*OW-1:0] lo_w [3];
  logic [2*OW-1:0] ro_w [3];
  logic            so_w [3];

  int   n_chk = 0;
  int   n_err = 0;
  exp_t q [3][3];
  int   fill [3];

  always #4 clk = ~clk;

  dif_butterfly #(.IW(IW), .CW(CW), .OW(OW), .SHIFT(SH), .CKPCE(1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce_v[0]), .sync_i(sync),
    .a_i(a), .b_i(b), .c_i(c), .left_o(lo_w[0]), .right_o(ro_w[0]), .sync_o(so_w[0]));
  dif_butterfly #(.IW(IW), .CW(CW), .OW(OW), .SHIFT(SH), .CKPCE(2)) dut2 (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce_v[1]), .sync_i(sync),
    .a_i(a), .b_i(b), .c_i(c), .left_o(lo_w[1]), .right_o(ro_w[1]), .sync_o(so_w[1]));
  dif_butterfly #(.IW(IW), .CW(CW), .OW(OW), .SHIFT(SH), .CKPCE(3)) dut3 (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce_v[2]), .sync_i(sync),
    .a_i(a), .b_i(b), .c_i(c), .left_o(lo_w[2]), .right_o(ro_w[2]), .sync_o(so_w[2]));

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic longint cround(input longint x, input int d);
    longint qv, rv, half;
    qv   = x >>> d;
    rv   = x - (qv <<< d);
    half = longint'(1) <<< (d - 1);
    if (rv > half || (rv == half && qv[0])) qv = qv + 1;
    return qv;
  endfunction

  function automatic logic [OW-1:0] wrap(input longint v);
    return v[OW-1:0];
  endfunction

  function automatic exp_t model(input logic [2*IW-1:0] av, bv, input logic [2*CW-1:0] cv,
                                 input bit sy);
    exp_t   e;
    longint ar, ai, br, bi, cr, ci, dr, di;
    ar = longint'($signed(av[2*IW-1:IW])); ai = longint'($signed(av[IW-1:0]));
    br = longint'($signed(bv[2*IW-1:IW])); bi = longint'($signed(bv[IW-1:0]));
    cr = longint'($signed(cv[2*CW-1:CW])); ci = longint'($signed(cv[CW-1:0]));
    dr = ar - br;
    di = ai - bi;
    e.l  = {wrap(ar + br), wrap(ai + bi)};
    e.r  = {wrap(cround(dr * cr - di * ci, PD)), wrap(cround(dr * ci + di * cr, PD))};
    e.sy = sy;
    return e;
  endfunction

  task automatic compare(input int j, input bit en);
    string tag;
    tag = $sformatf("R1 R2 R4 %s%s dut%0d", (j == 0) ? "R8" : "R9", en ? "" : " R5", j + 1);
    if (fill[j] >= 3) begin
      chk(lo_w[j] == q[j][2].l, {tag, " left"}, longint'(lo_w[j]), longint'(q[j][2].l));
      chk(ro_w[j] == q[j][2].r, {tag, " right"}, longint'(ro_w[j]), longint'(q[j][2].r));
      chk(so_w[j] == q[j][2].sy, $sformatf("R6 sync dut%0d", j + 1),
          longint'(so_w[j]), longint'(q[j][2].sy));
    end else begin
      chk(so_w[j] == 1'b0, $sformatf("R7 sync early dut%0d", j + 1), longint'(so_w[j]), 0);
    end
  endtask

  task automatic step(input bit [2:0] en, input logic [2*IW-1:0] av, bv,
                      input logic [2*CW-1:0] cv, input bit sy);
    exp_t e;
    @(negedge clk);
    ce_v = en; a = av; b = bv; c = cv; sync = sy;
    @(posedge clk);
    #1;
    e = model(av, bv, cv, sy);
    for (int j = 0; j < 3; j++) begin
      if (en[j]) begin
        q[j][2] = q[j][1];
        q[j][1] = q[j][0];
        q[j][0] = e;
        if (fill[j] < 3) fill[j]++;
      end
      compare(j, en[j]);
    end
  endtask

  function automatic logic [2*IW-1:0] pack_s(input int re, input int im);
    return {IW'(re), IW'(im)};
  endfunction

  function automatic logic [2*CW-1:0] coef(input int k);
    case (k % 8)
      0: return {CW'(16), CW'(0)};
      1: return {CW'(0), CW'(16)};
      2: return {CW'(-16), CW'(0)};
      3: return {CW'(0), CW'(-16)};
      4: return {CW'(11), CW'(-11)};
      5: return {CW'(-32), CW'(-32)};
      6: return {CW'(31), CW'(31)};
      default: return {CW'($urandom % 64), CW'($urandom % 64)};
    endcase
  endfunction

  function automatic logic [2*IW-1:0] rnd_s();
    return 2*IW'($urandom);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ce_v  = 3'b000;
    #1;
    for (int j = 0; j < 3; j++)
      chk(so_w[j] == 1'b0, $sformatf("R7 sync in reset dut%0d", j + 1), longint'(so_w[j]), 0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < 3; j++) fill[j] = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL R4 watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int r3_vals [4];
    int r3_exp  [4];
    for (int j = 0; j < 3; j++) fill[j] = 0;
    repeat (3) @(posedge clk);
    #1;
    for (int j = 0; j < 3; j++)
      chk(so_w[j] == 1'b0, $sformatf("R7 reset state dut%0d", j + 1), longint'(so_w[j]), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: continuous enable on the three-multiplier variant, real-part sweep
    for (int i = 0; i < 1024; i++)
      step(3'b001, pack_s((i / 32) - 16, int'($urandom % 32) - 16),
           pack_s((i % 32) - 16, int'($urandom % 32) - 16), coef(i), (i % 37) == 0);

    // R9, R5: all variants, gaps of 2..4 idle clocks with junk and stray sync
    for (int i = 0; i < 1024; i++) begin
      step(3'b111, pack_s((i % 32) - 16, int'($urandom % 32) - 16),
           pack_s((i / 32) - 16, int'($urandom % 32) - 16), coef(i + 3), (i % 29) == 0);
      for (int g = 0; g < 2 + (i % 3); g++)
        step(3'b000, rnd_s(), rnd_s(), {CW'($urandom), CW'($urandom)}, 1'b1);
    end

    // R7: reset with a sync in flight
    step(3'b111, rnd_s(), rnd_s(), coef(0), 1'b1);
    step(3'b000, rnd_s(), rnd_s(), coef(1), 1'b0);
    step(3'b000, rnd_s(), rnd_s(), coef(1), 1'b0);
    step(3'b111, rnd_s(), rnd_s(), coef(2), 1'b1);
    do_reset();
    for (int i = 0; i < 6; i++) begin
      step(3'b111, rnd_s(), rnd_s(), coef(i), 1'b0);
      step(3'b000, rnd_s(), rnd_s(), coef(i), 1'b1);
      step(3'b000, rnd_s(), rnd_s(), coef(i), 1'b1);
    end

    // R3: exact halves on the product path, c = 16 + 0j, shift 1
    r3_vals = '{1, 3, -1, 5};
    r3_exp  = '{0, 2, 0, 2};
    for (int k = 0; k < 6; k++) begin
      step(3'b001, (k < 4) ? pack_s(r3_vals[k], 0) : pack_s(0, 0), pack_s(0, 0),
           {CW'(16), CW'(0)}, 1'b0);
      if (k >= 2)
        chk($signed(ro_w[0][2*OW-1:OW]) == r3_exp[k-2], "R3 tie to even",
            longint'($signed(ro_w[0][2*OW-1:OW])), longint'(r3_exp[k-2]));
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule